// File: doc/BRIEF.md
# Selectable-Format Pixel Packer

This block sits between a pixel source and a memory write port. Each accepted input pixel carries four 8-bit channels (alpha, red, green, blue). The block reduces the pixel to one of twelve stored layouts, picked by a 4-bit format code: 16-bit 4444 and 565 layouts, 24-bit 888 layouts and 32-bit 8888 layouts, each in several channel orders. Channels are narrowed by keeping their most significant bits. The converted pixel bytes are streamed densely into 32-bit words. Each word carries one byte-lane strobe per byte.

The alpha field is either taken from the pixel, optionally inverted, or replaced by a constant that the invert bit selects. A 4-bit lane mask gates the strobes of every word. A pixel flagged as the last of a frame forces any partly filled word out, zero-padded, so the next frame starts word-aligned. Both sides use a valid/ready handshake. The output is held in one register. The configuration inputs are read with every pixel, but they should only change on a word boundary.

Top module: `pix_packer`

## Requirements
- R1: After reset, outValid is 0, inReady is 1 and no partly filled word is held.
- R2: The input pixel layout is inPixel[31:24]=A, [23:16]=R, [15:8]=G, [7:0]=B, and each channel is narrowed by keeping its top bits. Codes 0/1/2/3 give 16-bit pixels {A4,B4,G4,R4} / {A4,R4,G4,B4} / {B4,G4,R4,A4} / {R4,G4,B4,A4}, with the leftmost field in the most significant bits.
- R3: Codes 6 and 7 give 16-bit pixels {B5,G6,R5} and {R5,G6,B5}. Alpha is dropped.
- R4: Codes 8 and 9 give 24-bit pixels {B,G,R} and {R,G,B}. The bytes of consecutive pixels are packed with no gaps, so four pixels fill three words.
- R5: Codes 12/13/14/15 give 32-bit pixels {A,B,G,R} / {A,R,G,B} / {B,G,R,A} / {R,G,B,A}, one word per pixel.
- R6: Alpha handling depends on alphaEn and alphaInv. When alphaEn=1, the stored alpha is A, or ~A when alphaInv=1. When alphaEn=0, the stored alpha is 0xFF when alphaInv=0 and 0x00 when alphaInv=1.
- R7: Pixel bytes fill byte lanes from lane 0 upward, where lane i is outWord[8i+7:8i]. Inside each pixel the least significant byte comes first, so of two 16-bit pixels the first lands in the low half. For a full word, outStrobe[i] equals laneMask[i].
- R8: When a pixel with inLast=1 is accepted, inReady is 0 in the following cycle. Any leftover bytes are then emitted as one word, zero-padded above, with outStrobe = laneMask AND (lanes actually filled).
- R9: Codes 4, 5, 10 and 11 are unsupported. Each such pixel contributes four zero bytes, and fmtError is 1 while such a code is applied (0 otherwise).
- R10: While outValid=1 and outReady=0, outWord and outStrobe hold their values, outValid stays 1 and inReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block can take a pixel this cycle |
| inPixel | input | 32 | A,R,G,B channels, 8 bits each |
| inLast | input | 1 | Pixel is the last of a frame; flush afterwards |
| fmtCode | input | 4 | Stored layout selector |
| alphaEn | input | 1 | Store the pixel's alpha |
| alphaInv | input | 1 | Invert stored alpha, or pick the fill value |
| laneMask | input | 4 | Per-lane strobe gate |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer takes the word |
| outWord | output | 32 | Packed bytes, lane 0 lowest |
| outStrobe | output | 4 | Per-lane write enables |
| fmtError | output | 1 | Unsupported format code applied |

## Verification
The main hidden state is the count of leftover bytes and the buffer that holds them. A wrong count shifts every later byte of the frame by whole lanes, and this shows in the very next emitted word. A lost leftover shows as a missing or short flush word at frame end. A stuck flush state shows as inReady staying 0 one cycle after a last pixel, and the flow then stalls. Each stream is compared word by word, with strobes, against a byte model built from the requirements, under both free-flowing and stalling consumers.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = 8;
  localparam int WORD_W     = WORD_BYTES * LANE_W;
  localparam int HOLD_W     = WORD_W - LANE_W;        // at most WORD_BYTES-1 leftover bytes
  localparam int CAT_W      = WORD_W + HOLD_W;        // leftover plus one new pixel
  localparam int CNT_W      = $clog2(2 * WORD_BYTES); // byte counts up to 2*WORD_BYTES-1

  // control -> datapath strobes
  typedef struct packed {
    logic take;       // accept the converted pixel into the packer
    logic flushEmit;  // push leftover bytes out as a padded word
    logic pop;        // consumer takes the output word
  } packCmd_t;
endpackage

// File: rtl/pix_format_conv.sv
module pix_format_conv
  import pix_pack_pkg::*;
(
  input  logic [WORD_W-1:0] pixel,
  input  logic [3:0]        fmtCode,
  input  logic              alphaEn,
  input  logic              alphaInv,
  output logic [WORD_W-1:0] pixBytes,
  output logic [CNT_W-1:0]  pixSize,
  output logic              badFmt
);
  logic [7:0] chA, chR, chG, chB, alphaOut;

  assign chA = pixel[31:24];
  assign chR = pixel[23:16];
  assign chG = pixel[15:8];
  assign chB = pixel[7:0];

  always_comb begin
    if (alphaEn) alphaOut = alphaInv ? ~chA : chA;
    else         alphaOut = {8{~alphaInv}};
  end

  always_comb begin
    pixBytes = '0;
    pixSize  = CNT_W'(4);
    badFmt   = 1'b0;
    unique case (fmtCode)
      4'd0:  begin pixBytes = {16'h0, alphaOut[7:4], chB[7:4], chG[7:4], chR[7:4]}; pixSize = CNT_W'(2); end
      4'd1:  begin pixBytes = {16'h0, alphaOut[7:4], chR[7:4], chG[7:4], chB[7:4]}; pixSize = CNT_W'(2); end
      4'd2:  begin pixBytes = {16'h0, chB[7:4], chG[7:4], chR[7:4], alphaOut[7:4]}; pixSize = CNT_W'(2); end
      4'd3:  begin pixBytes = {16'h0, chR[7:4], chG[7:4], chB[7:4], alphaOut[7:4]}; pixSize = CNT_W'(2); end
      4'd6:  begin pixBytes = {16'h0, chB[7:3], chG[7:2], chR[7:3]}; pixSize = CNT_W'(2); end
      4'd7:  begin pixBytes = {16'h0, chR[7:3], chG[7:2], chB[7:3]}; pixSize = CNT_W'(2); end
      4'd8:  begin pixBytes = {8'h0, chB, chG, chR}; pixSize = CNT_W'(3); end
      4'd9:  begin pixBytes = {8'h0, chR, chG, chB}; pixSize = CNT_W'(3); end
      4'd12: pixBytes = {alphaOut, chB, chG, chR};
      4'd13: pixBytes = {alphaOut, chR, chG, chB};
      4'd14: pixBytes = {chB, chG, chR, alphaOut};
      4'd15: pixBytes = {chR, chG, chB, alphaOut};
      default: badFmt = 1'b1;  // zero word, full size
    endcase
  end
endmodule

// File: rtl/pix_pack_ctrl.sv
module pix_pack_ctrl
  import pix_pack_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             outReady,
  input  logic             outValid,
  input  logic [CNT_W-1:0] holdCnt,
  output logic             inReady,
  output packCmd_t         cmd
);
  typedef enum logic {ST_RUN, ST_FLUSH} ctrlState_t;
  ctrlState_t state, stateNext;
  logic outFree;

  assign outFree = !outValid || outReady;
  assign inReady = (state == ST_RUN) && outFree;

  always_comb begin
    cmd.take      = inValid && inReady;
    cmd.pop       = outValid && outReady;
    cmd.flushEmit = (state == ST_FLUSH) && (holdCnt != '0) && outFree;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (cmd.take && inLast) stateNext = ST_FLUSH;
      ST_FLUSH: if ((holdCnt == '0) || outFree) stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/pix_pack_dp.sv
module pix_pack_dp
  import pix_pack_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  packCmd_t              cmd,
  input  logic [WORD_W-1:0]     pixBytes,
  input  logic [CNT_W-1:0]      pixSize,
  input  logic [WORD_BYTES-1:0] laneMask,
  output logic [WORD_W-1:0]     outWord,
  output logic [WORD_BYTES-1:0] outStrobe,
  output logic                  outValid,
  output logic [CNT_W-1:0]      holdCnt
);
  logic [HOLD_W-1:0]     holdBuf;
  logic [CAT_W-1:0]      catBuf;
  logic [CNT_W-1:0]      totalCnt;
  logic                  fullWord;
  logic [WORD_BYTES-1:0] fillMask;

  // new pixel bytes land just above the leftover bytes
  assign catBuf   = ({{HOLD_W{1'b0}}, pixBytes} << {holdCnt, 3'b000})
                  | {{WORD_W{1'b0}}, holdBuf};
  assign totalCnt = holdCnt + pixSize;
  assign fullWord = totalCnt >= CNT_W'(WORD_BYTES);

  for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_fill
    assign fillMask[lane] = holdCnt > CNT_W'(lane);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord   <= '0;
      outStrobe <= '0;
      outValid  <= 1'b0;
      holdBuf   <= '0;
      holdCnt   <= '0;
    end else if (cmd.take) begin
      if (fullWord) begin
        outWord   <= catBuf[WORD_W-1:0];
        outStrobe <= laneMask;
        outValid  <= 1'b1;
        holdBuf   <= catBuf[CAT_W-1:WORD_W];
        holdCnt   <= totalCnt - CNT_W'(WORD_BYTES);
      end else begin
        holdBuf <= catBuf[HOLD_W-1:0];
        holdCnt <= totalCnt;
        if (cmd.pop) outValid <= 1'b0;
      end
    end else if (cmd.flushEmit) begin
      outWord   <= {{LANE_W{1'b0}}, holdBuf};
      outStrobe <= laneMask & fillMask;
      outValid  <= 1'b1;
      holdBuf   <= '0;
      holdCnt   <= '0;
    end else if (cmd.pop) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_packer.sv
module pix_packer
  import pix_pack_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [WORD_W-1:0]     inPixel,
  input  logic                  inLast,
  input  logic [3:0]            fmtCode,
  input  logic                  alphaEn,
  input  logic                  alphaInv,
  input  logic [WORD_BYTES-1:0] laneMask,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [WORD_W-1:0]     outWord,
  output logic [WORD_BYTES-1:0] outStrobe,
  output logic                  fmtError
);
  packCmd_t          cmd;
  logic [WORD_W-1:0] pixBytes;
  logic [CNT_W-1:0]  pixSize;
  logic [CNT_W-1:0]  holdCnt;

  pix_format_conv u_conv (
    .pixel(inPixel), .fmtCode(fmtCode), .alphaEn(alphaEn), .alphaInv(alphaInv),
    .pixBytes(pixBytes), .pixSize(pixSize), .badFmt(fmtError)
  );

  pix_pack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .outValid(outValid), .holdCnt(holdCnt),
    .inReady(inReady), .cmd(cmd)
  );

  pix_pack_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pixBytes(pixBytes), .pixSize(pixSize),
    .laneMask(laneMask), .outWord(outWord), .outStrobe(outStrobe),
    .outValid(outValid), .holdCnt(holdCnt)
  );
endmodule

// File: rtl/pix_packer_chk.sv
module pix_packer_chk
  import pix_pack_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  inReady,
  input logic                  inLast,
  input logic [3:0]            fmtCode,
  input logic                  fmtError,
  input logic [WORD_BYTES-1:0] laneMask,
  input logic                  outValid,
  input logic                  outReady,
  input logic [WORD_W-1:0]     outWord,
  input logic [WORD_BYTES-1:0] outStrobe,
  input logic [CNT_W-1:0]      holdCnt
);
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord) && $stable(outStrobe)));

  a_r10_block_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  a_r9_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && fmtError && holdCnt == '0) |=> (outValid && outWord == '0));

  a_r5_full_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && fmtCode[3:2] == 2'b11 && holdCnt == '0)
      |=> (outValid && outStrobe == $past(laneMask)));

  a_r8_flush_block: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  a_r4_hold_range: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt < CNT_W'(WORD_BYTES));
endmodule

bind pix_packer pix_packer_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inLast(inLast),
  .fmtCode(fmtCode), .fmtError(fmtError), .laneMask(laneMask),
  .outValid(outValid), .outReady(outReady), .outWord(outWord),
  .outStrobe(outStrobe), .holdCnt(holdCnt)
);

// File: tb/sim_pix_packer.sv
`timescale 1ns/1ps
module sim_pix_packer;
  logic clk = 1'b0;
  logic rstN, inValid, inLast, alphaEn, alphaInv;
  logic [31:0] inPixel;
  logic [3:0] fmtCode, laneMask;
  logic inReady, outValid, fmtError;
  logic [31:0] outWord;
  logic [3:0] outStrobe;
  logic outReady;
  int stallMode = 0;   // 0 free, 1 two of three, 2 never
  int cyc = 0;
  int total = 0, bad = 0;
  logic [31:0] expW[$], gotW[$];
  logic [3:0]  expS[$], gotS[$];
  logic [7:0]  byteQ[$];

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  assign outReady = (stallMode == 0) ? 1'b1 : (stallMode == 1) ? (cyc % 3 != 0) : 1'b0;

  pix_packer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPixel(inPixel),
    .inLast(inLast), .fmtCode(fmtCode), .alphaEn(alphaEn), .alphaInv(alphaInv),
    .laneMask(laneMask), .outValid(outValid), .outReady(outReady), .outWord(outWord),
    .outStrobe(outStrobe), .fmtError(fmtError)
  );

  // output monitor: sample 1 ns before the edge that completes the handshake
  initial forever begin
    @(negedge clk); #4;
    if (rstN && outValid && outReady) begin
      gotW.push_back(outWord);
      gotS.push_back(outStrobe);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  function automatic void model(input logic [3:0] f, input logic [31:0] p,
                                input logic aen, input logic ainv,
                                output logic [31:0] v, output int sz);
    logic [7:0] a, r, g, b;
    a = aen ? (ainv ? ~p[31:24] : p[31:24]) : (ainv ? 8'h00 : 8'hFF);
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    sz = 4; v = 32'h0;
    case (f)
      4'd0: begin v = {16'h0, a[7:4], b[7:4], g[7:4], r[7:4]}; sz = 2; end
      4'd1: begin v = {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]}; sz = 2; end
      4'd2: begin v = {16'h0, b[7:4], g[7:4], r[7:4], a[7:4]}; sz = 2; end
      4'd3: begin v = {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]}; sz = 2; end
      4'd6: begin v = {16'h0, b[7:3], g[7:2], r[7:3]}; sz = 2; end
      4'd7: begin v = {16'h0, r[7:3], g[7:2], b[7:3]}; sz = 2; end
      4'd8: begin v = {8'h0, b, g, r}; sz = 3; end
      4'd9: begin v = {8'h0, r, g, b}; sz = 3; end
      4'd12: v = {a, b, g, r};
      4'd13: v = {a, r, g, b};
      4'd14: v = {b, g, r, a};
      4'd15: v = {r, g, b, a};
      default: v = 32'h0;
    endcase
  endfunction

  // caller is at a negedge; returns at the negedge after acceptance
  task automatic sendPix(input logic [31:0] p, input logic last);
    bit taken;
    inValid = 1'b1; inPixel = p; inLast = last;
    taken = 0;
    while (!taken) begin
      #4;
      taken = inReady;
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic buildWords(input logic [3:0] mask);
    while (byteQ.size() >= 4) begin
      expW.push_back({byteQ[3], byteQ[2], byteQ[1], byteQ[0]});
      expS.push_back(mask);
      repeat (4) void'(byteQ.pop_front());
    end
    if (byteQ.size() > 0) begin
      logic [31:0] w = 32'h0;
      logic [3:0]  fill = 4'h0;
      for (int k = 0; k < byteQ.size(); k++) begin
        w[8*k +: 8] = byteQ[k];
        fill[k] = 1'b1;
      end
      expW.push_back(w);
      expS.push_back(mask & fill);
      byteQ.delete();
    end
  endtask

  task automatic compareAll(input string tag);
    for (int k = 0; k < 400 && (gotW.size() < expW.size() || outValid); k++)
      @(negedge clk);
    repeat (3) @(negedge clk);
    chk(gotW.size() == expW.size(), tag, "word count", gotW.size(), expW.size());
    for (int k = 0; k < expW.size() && k < gotW.size(); k++) begin
      chk(gotW[k] == expW[k], tag, $sformatf("word %0d data", k), gotW[k], expW[k]);
      chk(gotS[k] == expS[k], tag, $sformatf("word %0d strobe", k), {28'h0, gotS[k]}, {28'h0, expS[k]});
    end
    expW.delete(); expS.delete(); gotW.delete(); gotS.delete();
  endtask

  task automatic runStream(input logic [3:0] f, input logic aen, input logic ainv,
                           input logic [3:0] mask, input int n, input int seed,
                           input int stall, input string tag);
    logic [31:0] v;
    int sz;
    fmtCode = f; alphaEn = aen; alphaInv = ainv; laneMask = mask;
    stallMode = stall;
    for (int i = 0; i < n; i++) begin
      logic [31:0] p = 32'h9E3779B9 * (i + 1) + 32'(seed) * 32'h01234567;
      model(f, p, aen, ainv, v, sz);
      for (int k = 0; k < sz; k++) byteQ.push_back(v[8*k +: 8]);
      sendPix(p, i == n - 1);
    end
    buildWords(mask);
    stallMode = 0;
    compareAll(tag);
  endtask

  task automatic testReset();
    #4;
    chk(outValid == 1'b0, "R1", "outValid after reset", {31'h0, outValid}, 32'h0);
    chk(inReady == 1'b1, "R1", "inReady after reset", {31'h0, inReady}, 32'h1);
    @(negedge clk);
  endtask

  task automatic test4444();   // R2, R7, R8 (odd count leaves half word)
    for (int f = 0; f < 4; f++) runStream(4'(f), 1'b1, 1'b0, 4'hF, 3, f + 1, 0, "R2");
  endtask

  task automatic test565();    // R3
    runStream(4'd6, 1'b1, 1'b0, 4'hF, 4, 11, 0, "R3");
    runStream(4'd7, 1'b0, 1'b1, 4'hF, 4, 12, 1, "R3");
  endtask

  task automatic test888();    // R4 with stalling consumer for R10
    runStream(4'd8, 1'b1, 1'b0, 4'hF, 4, 21, 0, "R4");
    runStream(4'd9, 1'b1, 1'b0, 4'hF, 5, 22, 1, "R4");
  endtask

  task automatic test8888();   // R5, R6 all alpha settings
    runStream(4'd12, 1'b1, 1'b0, 4'hF, 2, 31, 0, "R5");
    runStream(4'd13, 1'b1, 1'b1, 4'hF, 2, 32, 0, "R6");
    runStream(4'd14, 1'b0, 1'b0, 4'hF, 2, 33, 0, "R6");
    runStream(4'd15, 1'b0, 1'b1, 4'hF, 2, 34, 1, "R6");
  endtask

  task automatic testMask();   // R7 lane gating, R8 flush strobes
    runStream(4'd9, 1'b1, 1'b0, 4'b0110, 2, 41, 0, "R7");
    runStream(4'd1, 1'b1, 1'b0, 4'b1011, 3, 42, 0, "R8");
  endtask

  task automatic testFlushGap();  // R8: inReady low right after a last pixel
    fmtCode = 4'd0; alphaEn = 1'b1; alphaInv = 1'b0; laneMask = 4'hF; stallMode = 0;
    begin
      logic [31:0] v; int sz;
      model(4'd0, 32'hA1B2C3D4, 1'b1, 1'b0, v, sz);
      for (int k = 0; k < sz; k++) byteQ.push_back(v[8*k +: 8]);
    end
    sendPix(32'hA1B2C3D4, 1'b1);
    #4;
    chk(inReady == 1'b0, "R8", "inReady after last", {31'h0, inReady}, 32'h0);
    @(negedge clk);
    buildWords(4'hF);
    compareAll("R8");
  endtask

  task automatic testBadFmt();  // R9
    fmtCode = 4'd5; #1;
    chk(fmtError == 1'b1, "R9", "fmtError code 5", {31'h0, fmtError}, 32'h1);
    fmtCode = 4'd13; #1;
    chk(fmtError == 1'b0, "R9", "fmtError code 13", {31'h0, fmtError}, 32'h0);
    @(negedge clk);
    runStream(4'd4, 1'b1, 1'b0, 4'hF, 2, 51, 0, "R9");
    runStream(4'd10, 1'b1, 1'b0, 4'hF, 1, 52, 0, "R9");
    runStream(4'd11, 1'b0, 1'b0, 4'hC, 1, 53, 1, "R9");
  endtask

  task automatic testBackpressure();  // R10
    logic [31:0] v0, v1; int sz;
    fmtCode = 4'd13; alphaEn = 1'b1; alphaInv = 1'b0; laneMask = 4'hF;
    stallMode = 2;
    model(4'd13, 32'h11223344, 1'b1, 1'b0, v0, sz);
    model(4'd13, 32'h55667788, 1'b1, 1'b0, v1, sz);
    sendPix(32'h11223344, 1'b0);
    inValid = 1'b1; inPixel = 32'h55667788; inLast = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #4;
      chk(outValid == 1'b1, "R10", "outValid held", {31'h0, outValid}, 32'h1);
      chk(inReady == 1'b0, "R10", "inReady blocked", {31'h0, inReady}, 32'h0);
      chk(outWord == v0, "R10", "outWord held", outWord, v0);
      @(negedge clk);
    end
    stallMode = 0;
    #4;
    chk(inReady == 1'b1, "R10", "inReady after release", {31'h0, inReady}, 32'h1);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    expW.push_back(v0); expS.push_back(4'hF);
    expW.push_back(v1); expS.push_back(4'hF);
    compareAll("R10");
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0; inPixel = '0;
    fmtCode = 4'd13; alphaEn = 1'b1; alphaInv = 1'b0; laneMask = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    test4444();
    test565();
    test888();
    test8888();
    testMask();
    testFlushGap();
    testBadFmt();
    testBackpressure();
    finishRun();
  end
endmodule